// File: doc/BRIEF.md
# Watchdog Timer with Paired-Clear Option

This block is a free-running watchdog counter for a small processor core. Software must restart the counter before it reaches its terminal count. If it does not, the block raises a one-cycle reset request while the core runs. If the core is halted, the block raises a one-cycle wake-up request instead. Two status flags let software find out why it is running: a timeout flag and a power-down flag.

A static configuration input selects how the counter is restarted. In single mode, one plain clear strobe restarts the count. In paired mode, the plain strobe is ignored. Two different half-clear strobes must both arrive, in either order and in the same or different cycles, before the count restarts. A half that arrives alone is held until its partner comes, or until the counter is restarted by a halt or a timeout, which discards it. A halt strobe restarts the counter and marks the core as powered down.

Top module: `wdg_pair_clear`

## Requirements
- R1: While the asynchronous active-low power-on reset is asserted, and for two clock edges after it is released, the counter, both flags, the halted state, any held half-clear, `rst_req_o` and `wake_o` are all 0.
- R2: The counter has CNT_W bits (default 15). It advances once per clock, so with no restart, 2^CNT_W clocks after the previous restart it reaches its terminal count of all ones. On that cycle, in normal mode, `rst_req_o` pulses high for one cycle, `to_o` becomes 1, and the counter wraps to 0.
- R3: With `cfg_pair_i`=0, `clr_i` restarts the counter and sets both `to_o` and `pdf_o` to 0. `clr_a_i` and `clr_b_i` have no effect.
- R4: With `cfg_pair_i`=1, `clr_i` has no effect on the counter or the flags.
- R5: With `cfg_pair_i`=1, the counter restarts and `to_o` and `pdf_o` are cleared once both `clr_a_i` and `clr_b_i` have been seen. They may arrive in either order, or in the same cycle.
- R6: With `cfg_pair_i`=1, a lone half-clear changes neither flag, does not restart the counter, and does not delay the next timeout.
- R7: `halt_i` restarts the counter, sets `pdf_o` to 1, sets `to_o` to 0 and enters the halted state.
- R8: A timeout while halted gives a one-cycle `wake_o` pulse and no `rst_req_o`. It sets `to_o`, leaves `pdf_o` unchanged and leaves the halted state.
- R9: A held half-clear is discarded when the counter is restarted by a halt or a timeout, so a later single opposite half does not restart the counter.
- R10: `halt_i` takes priority over a clear in the same cycle. A restart that lands on the terminal-count cycle suppresses the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running watchdog clock |
| rst_n | input | 1 | Power-on reset, asynchronous active low |
| cfg_pair_i | input | 1 | Static mode: 0 = single clear, 1 = paired clear |
| clr_i | input | 1 | Plain clear strobe |
| clr_a_i | input | 1 | First half-clear strobe |
| clr_b_i | input | 1 | Second half-clear strobe |
| halt_i | input | 1 | Halt strobe |
| rst_req_o | output | 1 | One-cycle reset request on timeout in normal mode |
| wake_o | output | 1 | One-cycle wake-up request on timeout while halted |
| to_o | output | 1 | Timeout flag |
| pdf_o | output | 1 | Power-down flag |

## Verification
The in-line properties check on every cycle how a halt and an effective clear act on the flags. They also check that the flags stay put when no event occurs, that the plain strobe and idle half-strobes never produce a clear in paired mode, and that the two request pulses never coincide and always come with the timeout flag set.

Only the bench scenarios can show the timing of a timeout measured from the last restart, the pairing of halves across cycles and in either order, and the discarding of a held half by a halt or a timeout. The same holds for a restart landing exactly on the terminal count. The bench shows these by comparing every output against a behavioural model on each clock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // One event acts on the watchdog per clock, in this priority order
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_HALT   = 2'd1,
    EV_CLEAR  = 2'd2,
    EV_EXPIRE = 2'd3
  } wdg_evt_e;
endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/wdg_clear_ctl.sv
module wdg_clear_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_pair_i,
  input  logic clr_i,
  input  logic clr_a_i,
  input  logic clr_b_i,
  input  logic drop_i,
  output logic clr_eff_o
);
  logic pend_a_q, pend_a_d;
  logic pend_b_q, pend_b_d;
  logic have_a, have_b;

  always_comb begin
    have_a    = cfg_pair_i & (clr_a_i | pend_a_q);
    have_b    = cfg_pair_i & (clr_b_i | pend_b_q);
    clr_eff_o = cfg_pair_i ? (have_a & have_b) : clr_i;
    pend_a_d  = pend_a_q;
    pend_b_d  = pend_b_q;
    if (drop_i || clr_eff_o) begin
      pend_a_d = 1'b0;
      pend_b_d = 1'b0;
    end else begin
      pend_a_d = have_a;
      pend_b_d = have_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_a_q <= 1'b0;
      pend_b_q <= 1'b0;
    end else begin
      pend_a_q <= pend_a_d;
      pend_b_q <= pend_b_d;
    end
  end

  // R4
  plain_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pair_i && !clr_a_i && !clr_b_i) |-> !clr_eff_o);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic terminal_o
);
  localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart_i) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign terminal_o = (cnt_q == TERM);

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    terminal_o |=> (cnt_q == '0));
endmodule

// File: rtl/wdg_status.sv
module wdg_status
  import wdg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wdg_evt_e evt_i,
  output logic     to_o,
  output logic     pdf_o,
  output logic     rst_req_o,
  output logic     wake_o
);
  logic to_q, to_d, pdf_q, pdf_d, hlt_q, hlt_d;
  logic rq_q, rq_d, wk_q, wk_d;

  always_comb begin
    to_d  = to_q;
    pdf_d = pdf_q;
    hlt_d = hlt_q;
    rq_d  = 1'b0;
    wk_d  = 1'b0;
    case (evt_i)
      EV_HALT: begin
        to_d  = 1'b0;
        pdf_d = 1'b1;
        hlt_d = 1'b1;
      end
      EV_CLEAR: begin
        to_d  = 1'b0;
        pdf_d = 1'b0;
      end
      EV_EXPIRE: begin
        to_d  = 1'b1;
        hlt_d = 1'b0;
        rq_d  = ~hlt_q;
        wk_d  = hlt_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q  <= 1'b0;
      pdf_q <= 1'b0;
      hlt_q <= 1'b0;
      rq_q  <= 1'b0;
      wk_q  <= 1'b0;
    end else begin
      to_q  <= to_d;
      pdf_q <= pdf_d;
      hlt_q <= hlt_d;
      rq_q  <= rq_d;
      wk_q  <= wk_d;
    end
  end

  assign to_o      = to_q;
  assign pdf_o     = pdf_q;
  assign rst_req_o = rq_q;
  assign wake_o    = wk_q;

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == EV_NONE) |=> ($stable(to_o) && $stable(pdf_o)));
  // R8
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req_o && wake_o));
  // R2
  req_with_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o || wake_o) |-> to_o);
endmodule

// File: rtl/wdg_pair_clear.sv
module wdg_pair_clear
  import wdg_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_pair_i,
  input  logic clr_i,
  input  logic clr_a_i,
  input  logic clr_b_i,
  input  logic halt_i,
  output logic rst_req_o,
  output logic wake_o,
  output logic to_o,
  output logic pdf_o
);
  logic     srst_n;
  logic     clr_eff, terminal, restart, drop;
  wdg_evt_e evt;

  wdg_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  always_comb begin
    if (halt_i)        evt = EV_HALT;
    else if (clr_eff)  evt = EV_CLEAR;
    else if (terminal) evt = EV_EXPIRE;
    else               evt = EV_NONE;
    restart = halt_i | clr_eff;
    drop    = (evt == EV_HALT) | (evt == EV_EXPIRE);
  end

  wdg_clear_ctl u_clr (
    .clk(clk), .rst_n(srst_n), .cfg_pair_i(cfg_pair_i),
    .clr_i(clr_i), .clr_a_i(clr_a_i), .clr_b_i(clr_b_i),
    .drop_i(drop), .clr_eff_o(clr_eff)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .restart_i(restart), .terminal_o(terminal)
  );

  wdg_status u_sts (
    .clk(clk), .rst_n(srst_n), .evt_i(evt),
    .to_o(to_o), .pdf_o(pdf_o), .rst_req_o(rst_req_o), .wake_o(wake_o)
  );

  // R7 R10
  halt_flags_chk: assert property (@(posedge clk) disable iff (!srst_n)
    halt_i |=> (pdf_o && !to_o));
  // R3 R5
  clear_flags_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (clr_eff && !halt_i) |=> (!pdf_o && !to_o && !rst_req_o && !wake_o));
endmodule

// File: tb/sim_wdg_pair_clear.sv
module sim_wdg_pair_clear;
  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n, cfg, c_any, c_a, c_b, h;
  logic rq, wk, to, pdf;
  int   n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  bit   done = 1'b0;

  // model state
  int m_cnt, m_sync;
  bit m_to, m_pdf, m_hlt, m_pa, m_pb, m_rq, m_wk;

  always #2.5 clk = ~clk;

  wdg_pair_clear #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pair_i(cfg), .clr_i(c_any),
    .clr_a_i(c_a), .clr_b_i(c_b), .halt_i(h),
    .rst_req_o(rq), .wake_o(wk), .to_o(to), .pdf_o(pdf)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sync = 0; m_to = 0; m_pdf = 0; m_hlt = 0;
      m_pa = 0; m_pb = 0; m_rq = 0; m_wk = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      bit ce, tmo;
      ce  = cfg ? ((c_a || m_pa) && (c_b || m_pb)) : c_any;
      tmo = (m_cnt == MAXV) && !h && !ce;
      m_rq = tmo && !m_hlt;
      m_wk = tmo && m_hlt;
      if (h) begin
        m_cnt = 0; m_pdf = 1; m_to = 0; m_hlt = 1; m_pa = 0; m_pb = 0;
      end else if (ce) begin
        m_cnt = 0; m_to = 0; m_pdf = 0; m_pa = 0; m_pb = 0;
      end else if (tmo) begin
        m_cnt = 0; m_to = 1; m_hlt = 0; m_pa = 0; m_pb = 0;
      end else begin
        m_cnt++;
        if (cfg) begin
          m_pa = m_pa || c_a;
          m_pb = m_pb || c_b;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      n_chk++;
      if (rq !== m_rq || wk !== m_wk || to !== m_to || pdf !== m_pdf) begin
        n_fail++;
        $display("FAIL %s cycle %0d: rst_req/wake/to/pdf actual %b%b%b%b expected %b%b%b%b",
                 cur_req, cyc, rq, wk, to, pdf, m_rq, m_wk, m_to, m_pdf);
      end
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input bit any, input bit a, input bit b, input bit hh);
    @(negedge clk);
    c_any = any; c_a = a; c_b = b; h = hh;
    @(negedge clk);
    c_any = 0; c_a = 0; c_b = 0; h = 0;
  endtask

  task automatic do_reset(input bit pair);
    rst_n = 0; cfg = pair;
    idle(4);
    @(negedge clk) rst_n = 1;
    idle(3);
  endtask

  initial begin
    rst_n = 0; cfg = 0; c_any = 0; c_a = 0; c_b = 0; h = 0;
    cur_req = "R1"; // R1: reset state
    do_reset(1'b0);

    cur_req = "R2"; // normal-mode timeout every 2^W clocks
    idle(600);

    cur_req = "R3"; // plain clear in single mode
    for (int i = 0; i < 6; i++) begin idle(100); strobe(1, 0, 0, 0); end
    for (int i = 0; i < 6; i++) begin idle(90); strobe(0, 1, 1, 0); end

    cur_req = "R7"; // halt
    strobe(0, 0, 0, 1);
    idle(20);
    cur_req = "R8"; // timeout while halted wakes
    idle(300);

    cur_req = "R10"; // halt beats clear in same cycle
    strobe(1, 0, 0, 1);
    idle(10);
    strobe(1, 0, 0, 0);
    for (int k = 250; k < 260; k++) begin idle(k); strobe(1, 0, 0, 0); end

    cur_req = "R1";
    do_reset(1'b1);

    cur_req = "R4"; // plain clear ignored in paired mode
    for (int i = 0; i < 6; i++) begin idle(100); strobe(1, 0, 0, 0); end

    cur_req = "R5"; // both halves, either order, same cycle
    strobe(0, 1, 0, 0); idle(10); strobe(0, 0, 1, 0);
    idle(50);
    strobe(0, 0, 1, 0); idle(10); strobe(0, 1, 0, 0);
    idle(50);
    strobe(0, 1, 1, 0);
    idle(100);

    cur_req = "R6"; // lone halves
    for (int i = 0; i < 8; i++) begin idle(60); strobe(0, 1, 0, 0); end

    cur_req = "R9"; // held half dropped by halt, then by timeout
    strobe(0, 1, 0, 0); idle(5);
    strobe(0, 0, 0, 1); idle(5);
    strobe(0, 0, 1, 0);
    idle(300);
    strobe(0, 0, 1, 0);
    idle(400);
    strobe(0, 1, 0, 0);
    idle(100);

    cur_req = "R10"; // pair completing on terminal count
    for (int k = 250; k < 260; k++) begin
      strobe(0, 1, 0, 0); idle(k - 2); strobe(0, 0, 1, 0);
    end
    idle(300);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule